// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This is the combinational integer arithmetic and logic unit of a scalar core's execute stage. It takes two operands and a three-bit operation code, and returns the result word, a carry-out, a zero indication and an overflow-exception request. The caller has already sign- or zero-extended any immediate, so both operands arrive at full width.

One shared adder does both add and subtract. For subtract, the B operand is inverted and the carry-in is forced to 1. Each arithmetic operation has a trapping form and a non-trapping form. The two forms give the same result bits, but only the trapping form can raise the overflow request. Overflow is the carry into the sign bit XORed with the carry out of it. The logical operations are AND, OR, XOR and NOR. NOR is a native operation rather than OR followed by an inversion step.

Top module: `int_alu_ovf`

## Requirements
- R1: The operation code `op_i` is decoded as 000 AND, 001 OR, 100 XOR and 101 NOR. NOR returns the bitwise inverse of (A OR B).
- R2: Codes 010 (trapping add) and 011 (non-trapping add) return (A + B) modulo 2^WIDTH. `carry_o` is bit WIDTH of the unsigned sum.
- R3: Codes 110 (trapping subtract) and 111 (non-trapping subtract) return (A − B) modulo 2^WIDTH. `carry_o` is 1 exactly when A ≥ B as unsigned numbers, meaning no borrow.
- R4: Codes 010 and 110 assert `ovf_o` exactly when the two's-complement result lies outside [−2^(WIDTH−1), 2^(WIDTH−1)−1].
- R5: Codes 011 and 111 never assert `ovf_o`, and their result and carry match their trapping counterparts.
- R6: For the logical codes (000, 001, 100, 101), `carry_o` and `ovf_o` are both 0.
- R7: `zero_o` is 1 exactly when every bit of `result_o` is 0, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| result_o | output | WIDTH | Result word |
| carry_o | output | 1 | Adder carry-out (no-borrow for subtract) |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow exception request |

## Verification
The block holds no state, so any fault shows at the ports as soon as the inputs settle. A wrong decode or a missing carry-in shows up as a result that is off by one or a sign-inverted operand. A wrong carry-chain tap shows up as an overflow flag that is wrong only at the signed boundaries, such as the maximum positive value plus one or the most negative value minus one. A four-bit instance is swept over every operand pair and code so that each boundary is reached. The full-width instance gets the directed extremes plus random vectors.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_ADDU = 3'b011,
    OP_XOR  = 3'b100,
    OP_NOR  = 3'b101,
    OP_SUB  = 3'b110,
    OP_SUBU = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOR = 2'b11
  } logic_sel_e;

  typedef struct packed {
    logic       arith;
    logic       sub;
    logic       trap;
    logic_sel_e lsel;
  } alu_ctrl_t;
endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
  import int_alu_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o.arith = op_i[1];
    ctrl_o.sub   = op_i[2] & op_i[1];
    ctrl_o.trap  = op_i[1] & ~op_i[0];
    ctrl_o.lsel  = logic_sel_e'({op_i[2], op_i[0]});
  end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic_sel_e       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LG_AND:  y_o[i] = a_i[i] & b_i[i];
        LG_OR:   y_o[i] = a_i[i] | b_i[i];
        LG_XOR:  y_o[i] = a_i[i] ^ b_i[i];
        default: y_o[i] = ~(a_i[i] | b_i[i]);
      endcase
    end
  end
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int LW = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [LW:0]      low;
  logic             c_msb;

  assign b_eff = sub_i ? ~b_i : b_i;
  // low part carries one spare bit to expose carry into the sign bit
  assign low   = {1'b0, a_i[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, sub_i};
  assign c_msb = low[LW];

  always_comb begin
    sum_o  = {a_i[LW] ^ b_eff[LW] ^ c_msb, low[LW-1:0]};
    cout_o = (a_i[LW] & b_eff[LW]) | (c_msb & (a_i[LW] ^ b_eff[LW]));
    ovf_o  = c_msb ^ cout_o;
  end

  logic [WIDTH:0] chk_sum;
  assign chk_sum = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});

  always_comb begin
    // R2 / R3: result bits match plain arithmetic
    a_r2_sum_bits: assert (sum_o == chk_sum[WIDTH-1:0]);
    // R4: sign-rule overflow agrees with carry-rule overflow
    a_r4_sign_rule: assert (ovf_o ==
      ((a_i[LW] == b_eff[LW]) && (sum_o[LW] != a_i[LW])));
  end
endmodule

// File: rtl/int_alu_ovf.sv
module int_alu_ovf
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             ovf_o
);
  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] lg_y, as_y;
  logic             as_c, as_v;

  int_alu_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  int_alu_logic #(.WIDTH(WIDTH)) u_lg (
    .sel_i(ctrl.lsel), .a_i(a_i), .b_i(b_i), .y_o(lg_y)
  );

  int_alu_addsub #(.WIDTH(WIDTH)) u_as (
    .sub_i(ctrl.sub), .a_i(a_i), .b_i(b_i),
    .sum_o(as_y), .cout_o(as_c), .ovf_o(as_v)
  );

  always_comb begin
    result_o = ctrl.arith ? as_y : lg_y;
    carry_o  = ctrl.arith & as_c;
    ovf_o    = ctrl.trap & as_v;
    zero_o   = ~|result_o;
  end

  always_comb begin
    // R5: non-trapping codes never raise the exception
    a_r5_no_trap: assert (!(op_i == OP_ADDU || op_i == OP_SUBU) || !ovf_o);
    // R6: logical codes keep flags low
    a_r6_logic_flags: assert (op_i[1] || (!carry_o && !ovf_o));
    // R7: zero flag is consistent with the logic result on logical codes
    a_r7_zero_logic: assert (op_i[1] || (zero_o == (lg_y == '0)));
  end
endmodule

// File: tb/int_alu_ovf_tb_top.sv
`timescale 1ns/1ps
module int_alu_ovf_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [2:0]  op32, op4;
  logic [31:0] a32, b32, r32;
  logic [3:0]  a4, b4, r4;
  logic        c32, z32, v32, c4, z4, v4;

  int_alu_ovf #(.WIDTH(32)) dut_i (
    .op_i(op32), .a_i(a32), .b_i(b32),
    .result_o(r32), .carry_o(c32), .zero_o(z32), .ovf_o(v32)
  );

  int_alu_ovf #(.WIDTH(4)) small_i (
    .op_i(op4), .a_i(a4), .b_i(b4),
    .result_o(r4), .carry_o(c4), .zero_o(z4), .ovf_o(v4)
  );

  task automatic model(input int w, input logic [2:0] op, input longint ua, input longint ub,
                       output longint er, output bit ec, output bit eo);
    longint mask, sa, sb, sv, t, mx, mn;
    mask = (longint'(1) << w) - 1;
    mx = (longint'(1) << (w - 1)) - 1;
    mn = -(longint'(1) << (w - 1));
    sa = ((ua >> (w - 1)) & 1) != 0 ? ua - (longint'(1) << w) : ua;
    sb = ((ub >> (w - 1)) & 1) != 0 ? ub - (longint'(1) << w) : ub;
    ec = 0; eo = 0; er = 0;
    case (op)
      3'b000: er = ua & ub;
      3'b001: er = ua | ub;
      3'b100: er = ua ^ ub;
      3'b101: er = ~(ua | ub) & mask;
      3'b010, 3'b011: begin
        t = ua + ub; er = t & mask; ec = ((t >> w) & 1) != 0;
        sv = sa + sb; eo = (op == 3'b010) && (sv > mx || sv < mn);
      end
      default: begin
        er = (ua - ub) & mask; ec = ua >= ub;
        sv = sa - sb; eo = (op == 3'b110) && (sv > mx || sv < mn);
      end
    endcase
  endtask

  function automatic string rtag(input logic [2:0] op);
    if (op == 3'b010 || op == 3'b011) return "R2";
    if (op == 3'b110 || op == 3'b111) return "R3";
    return "R1";
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp,
                     input logic [2:0] op, input longint ua, input longint ub);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h", req, what, op, ua, ub, act, exp);
    end
  endtask

  task automatic compare(input int w, input logic [2:0] op, input longint ua, input longint ub,
                         input longint ar, input bit ac, input bit az, input bit av);
    longint er; bit ec, eo;
    string ctag, vtag;
    model(w, op, ua, ub, er, ec, eo);
    ctag = op[1] ? (op[2] ? "R3" : "R2") : "R6";
    vtag = op[1] ? (op[0] ? "R5" : "R4") : "R6";
    chk(rtag(op), "result", ar, er, op, ua, ub);
    chk(ctag, "carry", longint'(ac), longint'(ec), op, ua, ub);
    chk(vtag, "ovf", longint'(av), longint'(eo), op, ua, ub);
    chk("R7", "zero", longint'(az), longint'(er == 0), op, ua, ub);
  endtask

  task automatic run32(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    op32 = op; a32 = a; b32 = b;
    @(negedge clk);
    compare(32, op, longint'(a), longint'(b), longint'(r32), c32, z32, v32);
  endtask

  initial begin
    op32 = '0; a32 = '0; b32 = '0; op4 = '0; a4 = '0; b4 = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state: AND of zeros gives zero result, flags low (R7, R6)
    chk("R7", "idle zero", longint'(z32), 1, 3'b000, 0, 0);
    chk("R6", "idle carry", longint'(c32), 0, 3'b000, 0, 0);
    chk("R6", "idle ovf", longint'(v32), 0, 3'b000, 0, 0);

    // R4 boundaries: max positive + 1, most negative - 1
    run32(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
    run32(3'b011, 32'h7FFF_FFFF, 32'h0000_0001);
    run32(3'b110, 32'h8000_0000, 32'h0000_0001);
    run32(3'b111, 32'h8000_0000, 32'h0000_0001);
    run32(3'b010, 32'h8000_0000, 32'h8000_0000);
    run32(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
    run32(3'b110, 32'h0000_0000, 32'h8000_0000);
    run32(3'b110, 32'h1234_5678, 32'h1234_5678);
    run32(3'b101, 32'h0000_0000, 32'h0000_0000);
    run32(3'b101, 32'hFFFF_0000, 32'h0000_FFFF);
    run32(3'b100, 32'hA5A5_A5A5, 32'hA5A5_A5A5);

    for (int i = 0; i < 1600; i++)
      run32(3'($urandom_range(7)), $urandom, $urandom);

    // exhaustive sweep on the 4-bit instance
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          op4 = 3'(op); a4 = 4'(a); b4 = 4'(b);
          @(negedge clk);
          compare(4, 3'(op), longint'(a), longint'(b), longint'(r4), c4, z4, v4);
        end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule